// File: doc/BRIEF.md
# I/Q Serial Output Formatter

This block turns pairs of 12-bit in-phase (I) and quadrature (Q) receive samples into a synchronous serial stream for a signal processor. Samples are offered one pair at a time through a valid/ready handshake and held in a one-pair holding register. The block divides its system clock down to a serial clock. It sends each pair as one frame of 24 bit slots and marks the start of every frame that carries a pair with a sync pulse.

Two static controls choose among four output formats. The format input selects either a shared layout or a split layout. In the shared layout, I and then Q go out on the primary data pin and the secondary pin flags which word is on the wire. In the split layout, I and Q go out together on the two pins. The rate input selects the half-period of the serial clock, so the pair rate changes by a factor of two. With a 26 MHz system clock and the default dividers, the pair rate is 270.8 kHz on the slow setting and 541.7 kHz on the fast one.

A sleep input stops the block at once. After reset or after sleep is released, the first frames are sent muted for as long as the upstream filter needs to settle (288 serial-clock periods by default). The block also registers a pad output-enable for the two data pins.

Top module: `iq_serial_formatter`

## Requirements
- R1: While rst is high, in the cycle after it, sclk, sdata_a, sdata_b, sync, data_oe and in_ready are all 0.
- R2: Each bit slot starts with a rising edge of sclk, and the data pins change only at that edge. sclk is high for the first half of the slot and low for the second half. The half length is 2 system clocks when fast_rate is 0 and 1 clock when it is 1. A frame is 24 slots, numbered 0 to 23.
- R3: With fmt_split=0 (shared layout), sdata_a carries I bit 11 down to bit 0 in slots 0 to 11, then Q bit 11 down to bit 0 in slots 12 to 23. sdata_b is 0 in slots 0 to 11 and 1 in slots 12 to 23.
- R4: With fmt_split=1 (split layout), sdata_a carries I and sdata_b carries Q, bit 11 first, in slots 0 to 11. Both pins are 0 in slots 12 to 23.
- R5: sync is 1 for the whole of slot 0 of every frame that carries a sample pair, and 0 at all other times.
- R6: fmt_split and fast_rate are sampled only when slot 0 of a frame begins. A change in the middle of a frame takes effect at the next frame.
- R7: After reset or sleep release, the first 12 frames (288 slots) carry no data. Sync stays low and the data bits are 0. A pair held when such a frame starts is discarded.
- R8: in_ready is 1 when the block is running, sleep is low and the holding register is empty. A pair moves to the serializer when a frame starts. A frame that starts with no pair held sends 0 data bits and no sync.
- R9: data_oe equals out_enable from the previous clock, and is forced to 0 when sleep was high.
- R10: One clock after sleep is sampled high, sclk, sync and both data pins are 0 and the holding register is emptied. On the first clock with sleep low, slot 0 of a new frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Stops and clears the block while high |
| fmt_split | input | 1 | 0: shared pin with I/Q flag, 1: separate I and Q pins |
| fast_rate | input | 1 | 0: slow serial clock, 1: double-speed serial clock |
| out_enable | input | 1 | Requests driving of the data pads |
| in_valid | input | 1 | A sample pair is offered |
| in_i | input | 12 | In-phase sample |
| in_q | input | 12 | Quadrature sample |
| in_ready | output | 1 | Holding register can take a pair |
| sclk | output | 1 | Serial clock |
| sdata_a | output | 1 | Primary serial data |
| sdata_b | output | 1 | I/Q flag (shared layout) or Q data (split layout) |
| sync | output | 1 | Frame-start marker |
| data_oe | output | 1 | Pad output-enable for the data pins |

## Verification
The bench drives several sample patterns through both layouts and both rates: all-ones against all-zeros, a walking one against its complement, alternating bits, and counting values. These tell apart bit-order, I/Q swap and slot-offset errors. Format and rate are switched in the middle of a frame to separate sampling at the frame boundary from immediate response. Pauses in the feed show whether starved frames stay silent, and a mid-frame sleep followed by a full settling window confirms muting, the restart at slot 0, and that pairs offered during settling are dropped.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  typedef enum logic {
    FMT_SHARED = 1'b0,
    FMT_SPLIT  = 1'b1
  } fmt_e;
endpackage

// File: rtl/iqf_timing.sv
// Serial clock, slot and frame sequencing, settling window.
module iqf_timing #(
  parameter int FRAME_SLOTS   = 24,
  parameter int HALF_SLOW     = 2,
  parameter int HALF_FAST     = 1,
  parameter int SETTLE_FRAMES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  input  logic rate_in,
  output logic run,
  output logic bnd,
  output logic fstart,
  output logic [$clog2(FRAME_SLOTS)-1:0] next_slot,
  output logic muted_next,
  output logic sclk
);
  localparam int HMAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int PH_W  = (2 * HMAX > 2) ? $clog2(2 * HMAX) : 1;
  localparam int SLT_W = $clog2(FRAME_SLOTS);
  localparam int SET_W = $clog2(SETTLE_FRAMES + 1);

  logic [PH_W-1:0]  ph_q, last_ph, half_cur, ph_nx;
  logic [SLT_W-1:0] slot_q;
  logic [SET_W-1:0] settle_q;
  logic             rate_q, run_q, sclk_q;

  always_comb begin
    half_cur  = rate_q ? PH_W'(HALF_FAST) : PH_W'(HALF_SLOW);
    last_ph   = rate_q ? PH_W'(2 * HALF_FAST - 1) : PH_W'(2 * HALF_SLOW - 1);
    ph_nx     = ph_q + PH_W'(1);
    bnd       = !sleep && (!run_q || ph_q == last_ph);
    next_slot = (!run_q || slot_q == SLT_W'(FRAME_SLOTS - 1)) ? '0 : slot_q + SLT_W'(1);
    fstart    = bnd && (next_slot == '0);
  end

  assign muted_next = (settle_q != '0);
  assign run        = run_q;
  assign sclk       = sclk_q;

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      run_q    <= 1'b0;
      ph_q     <= '0;
      slot_q   <= '0;
      sclk_q   <= 1'b0;
      rate_q   <= 1'b0;
      settle_q <= SET_W'(SETTLE_FRAMES);
    end else begin
      run_q <= 1'b1;
      if (bnd) begin
        ph_q   <= '0;
        slot_q <= next_slot;
        sclk_q <= 1'b1;
        if (fstart) begin
          rate_q <= rate_in;
          if (settle_q != '0) settle_q <= settle_q - SET_W'(1);
        end
      end else begin
        ph_q   <= ph_nx;
        sclk_q <= (ph_nx < half_cur);
      end
    end
  end
endmodule

// File: rtl/iqf_holding.sv
// One-pair holding register with valid/ready capture.
module iqf_holding #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         run,
  input  logic         take,
  input  logic         in_valid,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic         in_ready,
  output logic         pend,
  output logic [W-1:0] hold_i,
  output logic [W-1:0] hold_q
);
  logic pend_q;

  assign in_ready = run && !sleep && !pend_q;
  assign pend     = pend_q;

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      pend_q <= 1'b0;
      hold_i <= '0;
      hold_q <= '0;
    end else if (take && pend_q) begin
      pend_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      pend_q <= 1'b1;
      hold_i <= in_i;
      hold_q <= in_q;
    end
  end
endmodule

// File: rtl/iqf_shifter.sv
// Frame shift registers and pin formatting for both layouts.
module iqf_shifter
  import iqf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         bnd,
  input  logic         fstart,
  input  logic [$clog2(2*W)-1:0] next_slot,
  input  logic         load_ok,
  input  logic [W-1:0] hold_i,
  input  logic [W-1:0] hold_q,
  input  logic         mode_in,
  output logic         pin_a,
  output logic         pin_b,
  output logic         sync
);
  localparam int FW = 2 * W;

  fmt_e          mode_q, mode_n;
  logic [FW-1:0] wa_q, wb_q, wa_n, wb_n;

  always_comb begin
    mode_n = fstart ? fmt_e'(mode_in) : mode_q;
    if (fstart) begin
      if (!load_ok)              wa_n = '0;
      else if (mode_n == FMT_SPLIT) wa_n = {hold_i, W'(0)};
      else                       wa_n = {hold_i, hold_q};
      wb_n = (load_ok && mode_n == FMT_SPLIT) ? {hold_q, W'(0)} : '0;
    end else begin
      wa_n = {wa_q[FW-2:0], 1'b0};
      wb_n = {wb_q[FW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      mode_q <= FMT_SHARED;
      wa_q   <= '0;
      wb_q   <= '0;
      pin_a  <= 1'b0;
      pin_b  <= 1'b0;
      sync   <= 1'b0;
    end else if (bnd) begin
      mode_q <= mode_n;
      wa_q   <= wa_n;
      wb_q   <= wb_n;
      pin_a  <= wa_n[FW-1];
      pin_b  <= (mode_n == FMT_SHARED) ? (int'(next_slot) >= W) : wb_n[FW-1];
      sync   <= fstart && load_ok;
    end
  end
endmodule

// File: rtl/iq_serial_formatter.sv
module iq_serial_formatter #(
  parameter int W             = 12,
  parameter int HALF_SLOW     = 2,
  parameter int HALF_FAST     = 1,
  parameter int SETTLE_SLOTS  = 288
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         fmt_split,
  input  logic         fast_rate,
  input  logic         out_enable,
  input  logic         in_valid,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic         in_ready,
  output logic         sclk,
  output logic         sdata_a,
  output logic         sdata_b,
  output logic         sync,
  output logic         data_oe
);
  localparam int FRAME_SLOTS   = 2 * W;
  localparam int SETTLE_FRAMES = (SETTLE_SLOTS + FRAME_SLOTS - 1) / FRAME_SLOTS;
  localparam int SLT_W         = $clog2(FRAME_SLOTS);

  logic             run, bnd, fstart, muted_next, pend;
  logic [SLT_W-1:0] next_slot;
  logic [W-1:0]     hold_i, hold_q;

  iqf_timing #(
    .FRAME_SLOTS(FRAME_SLOTS), .HALF_SLOW(HALF_SLOW),
    .HALF_FAST(HALF_FAST), .SETTLE_FRAMES(SETTLE_FRAMES)
  ) u_timing (
    .clk(clk), .rst(rst), .sleep(sleep), .rate_in(fast_rate),
    .run(run), .bnd(bnd), .fstart(fstart), .next_slot(next_slot),
    .muted_next(muted_next), .sclk(sclk)
  );

  iqf_holding #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .sleep(sleep), .run(run), .take(fstart),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_ready(in_ready),
    .pend(pend), .hold_i(hold_i), .hold_q(hold_q)
  );

  iqf_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .sleep(sleep), .bnd(bnd), .fstart(fstart),
    .next_slot(next_slot), .load_ok(pend && !muted_next),
    .hold_i(hold_i), .hold_q(hold_q), .mode_in(fmt_split),
    .pin_a(sdata_a), .pin_b(sdata_b), .sync(sync)
  );

  always_ff @(posedge clk) begin
    if (rst) data_oe <= 1'b0;
    else     data_oe <= out_enable && !sleep;
  end
endmodule

// File: rtl/iqf_checker.sv
module iqf_checker (
  input logic clk,
  input logic rst,
  input logic sleep,
  input logic out_enable,
  input logic in_ready,
  input logic sclk,
  input logic sdata_a,
  input logic sdata_b,
  input logic sync,
  input logic data_oe
);
  assert_data_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sdata_a) && !$past(sleep)) |-> $rose(sclk));

  assert_sync_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sync) |-> $rose(sclk));

  assert_ready_low_R8: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !in_ready);

  assert_oe_track_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (data_oe == ($past(out_enable) && !$past(sleep))));

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!sclk && !sync && !sdata_a && !sdata_b));
endmodule

bind iq_serial_formatter iqf_checker u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .out_enable(out_enable),
  .in_ready(in_ready), .sclk(sclk), .sdata_a(sdata_a), .sdata_b(sdata_b),
  .sync(sync), .data_oe(data_oe)
);

// File: tb/iq_serial_formatter_test.sv
module iq_serial_formatter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, sleep = 1'b0, fmt_split = 1'b0, fast_rate = 1'b0;
  logic out_enable = 1'b1, in_valid = 1'b0;
  logic [11:0] in_i = '0, in_q = '0;
  logic in_ready, sclk, sdata_a, sdata_b, sync, data_oe;

  iq_serial_formatter uut (
    .clk(clk), .rst(rst), .sleep(sleep), .fmt_split(fmt_split),
    .fast_rate(fast_rate), .out_enable(out_enable), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .in_ready(in_ready), .sclk(sclk),
    .sdata_a(sdata_a), .sdata_b(sdata_b), .sync(sync), .data_oe(data_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, k = 0, dut_syncs = 0;
  bit feed = 0, done = 0, prev_sync = 0;

  // reference model state
  bit m_run = 0, m_pend = 0, m_data = 0, m_mode = 0, m_took = 0;
  bit m_sclk = 0, m_a = 0, m_b = 0, m_sync = 0, m_oe = 0;
  int m_ph = 0, m_slot = 0, m_half = 2, m_settle = 12;
  logic [11:0] p_i = '0, p_q = '0, c_i = '0, c_q = '0;

  function automatic logic [23:0] gen(int n);
    case (n % 4)
      0: gen = {12'hFFF, 12'h000};
      1: gen = {12'(1 << (n % 12)), ~12'(1 << (n % 12))};
      2: gen = {12'hAAA, 12'h555};
      default: gen = {12'(n * 37), 12'(n * 91 + 5)};
    endcase
  endfunction

  always @(posedge clk) begin
    bit acc;
    int ns;
    m_took = 0;
    if (rst || sleep) begin
      m_run = 0; m_ph = 0; m_slot = 0; m_settle = 12; m_pend = 0; m_data = 0;
      m_sclk = 0; m_a = 0; m_b = 0; m_sync = 0; m_mode = 0; m_half = 2;
    end else begin
      acc = in_valid && m_run && !m_pend;
      if (!m_run || m_ph == 2 * m_half - 1) begin
        ns = (!m_run || m_slot == 23) ? 0 : m_slot + 1;
        if (ns == 0) begin
          m_mode = fmt_split;
          m_half = fast_rate ? 1 : 2;
          m_data = m_pend && (m_settle == 0);
          if (m_data) begin c_i = p_i; c_q = p_q; end
          m_pend = 0;
          if (m_settle > 0) m_settle--;
        end
        m_slot = ns; m_ph = 0;
      end else m_ph++;
      m_run = 1;
      if (acc) begin m_pend = 1; p_i = in_i; p_q = in_q; m_took = 1; end
      m_sclk = (m_ph < m_half);
      m_sync = m_data && (m_slot == 0);
      if (!m_mode) begin
        m_a = !m_data ? 1'b0 : (m_slot < 12 ? c_i[11 - m_slot] : c_q[23 - m_slot]);
        m_b = (m_slot >= 12);
      end else begin
        m_a = m_data && m_slot < 12 && c_i[11 - m_slot];
        m_b = m_data && m_slot < 12 && c_q[11 - m_slot];
      end
    end
    m_oe = !rst && out_enable && !sleep;
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        chk("R1", "sclk", sclk, 1'b0);
        chk("R1", "sdata_a", sdata_a, 1'b0);
        chk("R1", "sync", sync, 1'b0);
        chk("R1", "data_oe", data_oe, 1'b0);
        chk("R1", "in_ready", in_ready, 1'b0);
      end else begin
        chk("R2", "sclk", sclk, m_sclk);
        chk("R5", "sync", sync, m_sync);
        chk(m_mode ? "R4" : "R3", "sdata_a", sdata_a, m_a);
        chk(m_mode ? "R4" : "R3", "sdata_b", sdata_b, m_b);
        chk("R8", "in_ready", in_ready, m_run && !m_pend && !sleep);
        chk("R9", "data_oe", data_oe, m_oe);
      end
      if (sync && !prev_sync) dut_syncs++;
      prev_sync = sync;
    end
  end

  // sample feeder
  always begin
    @(negedge clk); #1;
    if (m_took) k++;
    in_valid = feed;
    {in_i, in_q} = gen(k);
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int snap;
    wait_cycles(4);
    rst = 0; feed = 1;
    // R7: settling window at slow rate is 12 frames of 96 clocks
    wait_cycles(1100);
    checks++; if (dut_syncs != 0) begin errors++;
      $display("FAIL R7 syncs during settle actual=%0d expected=0", dut_syncs); end
    wait_cycles(350);
    checks++; if (dut_syncs == 0) begin errors++;
      $display("FAIL R7 syncs after settle actual=%0d expected>0", dut_syncs); end
    // R6: format change mid-frame applies at next frame only
    wait_cycles(37);
    fmt_split = 1;
    for (int c = 0; c < 40; c++) begin
      wait_cycles(1);
      chk("R6", "sdata_b", sdata_b, m_b);
    end
    wait_cycles(300);
    // R6: rate change mid-frame
    wait_cycles(13);
    fast_rate = 1;
    for (int c = 0; c < 30; c++) begin
      wait_cycles(1);
      chk("R6", "sclk", sclk, m_sclk);
    end
    wait_cycles(200);
    // R8: starvation keeps frames silent
    feed = 0;
    wait_cycles(120);
    snap = dut_syncs;
    out_enable = 0;
    wait_cycles(150);
    out_enable = 1;
    checks++; if (dut_syncs != snap) begin errors++;
      $display("FAIL R8 syncs while starved actual=%0d expected=%0d", dut_syncs, snap); end
    feed = 1;
    fmt_split = 0;
    wait_cycles(250);
    // R10: sleep in the middle of a frame
    wait_cycles(7);
    sleep = 1;
    wait_cycles(1);
    chk("R10", "sclk", sclk, 1'b0);
    chk("R10", "sdata_b", sdata_b, 1'b0);
    chk("R10", "in_ready", in_ready, 1'b0);
    wait_cycles(9);
    sleep = 0;
    wait_cycles(1);
    chk("R10", "sclk restart", sclk, 1'b1);
    snap = dut_syncs;
    wait_cycles(560);
    checks++; if (dut_syncs != snap) begin errors++;
      $display("FAIL R7 syncs during resettle actual=%0d expected=%0d", dut_syncs, snap); end
    wait_cycles(200);
    fmt_split = 1;
    wait_cycles(200);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule